// File: doc/BRIEF.md
# Block-XOR Parameter Extractor

This unit condenses a 14-bit data word into a 4-bit signature that a parameter-filtered content-addressable memory uses as a first, cheap search stage. Only the entries whose stored signature equals the signature of the search key go on to the full data comparison. The data bits are divided into four disjoint groups. Each group is folded by XOR into one signature bit, so a change to any single data bit flips exactly one signature bit.

One of the sixteen signature values is held back to mark an empty or invalid entry, and that value is all ones. A 4-input AND gate detects when the folded result of a valid word lands on the reserved value. A multiplexer then substitutes a replacement code that is built from the same word. Valid words therefore never carry the empty marker, and they stay spread over the other fifteen codes, at about 2^14/15 words per code.

The output can be taken straight from the logic, or from a single output register chosen by a parameter. The register resets synchronously to the empty marker.

Top module: `bxpe_param_extract`

## Requirements
- R1: With valid high and a folded result other than 4'b1111, output bit 0 is the XOR of data[3:0], bit 1 the XOR of data[7:4], bit 2 the XOR of data[10:8] and bit 3 the XOR of data[13:11].
- R2: With valid low, the output is 4'b1111 whatever the data.
- R3: With valid high, the output is never 4'b1111, for any of the 2^14 data words.
- R4: With valid high and a folded result of 4'b1111, the output is {1'b0, fold(data[13:11]) ^ data[0], fold(data[10:8]) ^ data[1], XOR of all 14 data bits}.
- R5: Across all 2^14 data words with valid high, each of the 15 codes 4'h0 to 4'hE appears at least once.
- R6: With REG_OUT=1 (the default), the output reflects the inputs sampled at the previous rising clock edge. With REG_OUT=0, it reflects the current inputs.
- R7: With REG_OUT=1, a synchronous active-high reset drives the output to 4'b1111, and the output stays there for as long as reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| data_i | input | 14 | Data word to condense |
| valid_i | input | 1 | High when data_i holds a real entry |
| param_o | output | 4 | Signature code; 4'b1111 marks an empty entry |

## Verification
The only state is the output register, so a wrong internal value appears on param_o one cycle after the inputs that caused it. A wrong value can show in three ways. A valid word can carry the empty marker. A single data-bit flip can move the wrong signature bit. A word whose groups all fold to one can take a replacement code other than the one built from bits 0, 1 and the whole-word parity. A full sweep of all data words compares every code against an independent model and confirms that all fifteen codes appear. Short directed vectors cover the remap cases, forced-empty inputs and the reset value.

// File: rtl/bxpe_pkg.sv
package bxpe_pkg;

    localparam int DATA_W  = 14;
    localparam int NUM_BLK = 4;
    localparam int PARAM_W = NUM_BLK;

    typedef logic [PARAM_W-1:0] param_t;

    // All-ones signature is held back as the empty-entry marker.
    localparam param_t EMPTY_CODE = '1;

    // Folded signature together with its collision flag.
    typedef struct packed {
        param_t raw;
        logic   collide;
    } fold_res_t;

    // Lowest bit of block k. The first (dw % nb) blocks take one extra bit.
    function automatic int blk_lo(input int k, input int dw, input int nb);
        int base;
        int rem;
        base = dw / nb;
        rem  = dw % nb;
        return k * base + ((k < rem) ? k : rem);
    endfunction

    // Width of block k.
    function automatic int blk_width(input int k, input int dw, input int nb);
        int base;
        int rem;
        base = dw / nb;
        rem  = dw % nb;
        return base + ((k < rem) ? 1 : 0);
    endfunction

endpackage

// File: rtl/bxpe_block_fold.sv
module bxpe_block_fold #(
    parameter int W = 4
) (
    input  logic [W-1:0] bits_i,
    output logic         fold_o
);

    always_comb begin
        fold_o = 1'b0;
        for (int j = 0; j < W; j++) begin
            fold_o = fold_o ^ bits_i[j];
        end
    end

endmodule

// File: rtl/bxpe_remap.sv
module bxpe_remap #(
    parameter int DATA_W  = bxpe_pkg::DATA_W,
    parameter int NUM_BLK = bxpe_pkg::NUM_BLK
) (
    input  logic [DATA_W-1:0]  data_i,
    input  logic               valid_i,
    input  logic [NUM_BLK-1:0] raw_i,
    output logic [NUM_BLK-1:0] code_o
);

    logic               collide;
    logic [NUM_BLK-1:0] alt_code;
    logic               word_par;

    // AND detect: the folded result landed on the reserved code.
    assign collide  = &raw_i;
    assign word_par = ^data_i;

    // Replacement code: top bit cleared so it can never be all ones.
    assign alt_code[NUM_BLK-1] = 1'b0;
    assign alt_code[0]         = word_par;

    genvar k;
    generate
        for (k = 1; k < NUM_BLK - 1; k++) begin : g_alt
            assign alt_code[k] = raw_i[k+1] ^ data_i[NUM_BLK-2-k];
        end
    endgenerate

    always_comb begin
        if (!valid_i) begin
            code_o = '1;
        end else if (collide) begin
            code_o = alt_code;
        end else begin
            code_o = raw_i;
        end
    end

endmodule

// File: rtl/bxpe_param_extract.sv
module bxpe_param_extract #(
    parameter int DATA_W  = bxpe_pkg::DATA_W,
    parameter int NUM_BLK = bxpe_pkg::NUM_BLK,
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DATA_W-1:0]  data_i,
    input  logic               valid_i,
    output logic [NUM_BLK-1:0] param_o
);

    logic [NUM_BLK-1:0] raw;
    logic [NUM_BLK-1:0] code_next;

    genvar k;
    generate
        for (k = 0; k < NUM_BLK; k++) begin : g_blk
            localparam int LO = bxpe_pkg::blk_lo(k, DATA_W, NUM_BLK);
            localparam int BW = bxpe_pkg::blk_width(k, DATA_W, NUM_BLK);
            bxpe_block_fold #(.W(BW)) u_fold (
                .bits_i (data_i[LO +: BW]),
                .fold_o (raw[k])
            );
        end
    endgenerate

    bxpe_remap #(.DATA_W(DATA_W), .NUM_BLK(NUM_BLK)) u_remap (
        .data_i  (data_i),
        .valid_i (valid_i),
        .raw_i   (raw),
        .code_o  (code_next)
    );

    generate
        if (REG_OUT) begin : g_reg
            logic [NUM_BLK-1:0] param_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    param_q <= '1;
                end else begin
                    param_q <= code_next;
                end
            end
            assign param_o = param_q;
        end else begin : g_comb
            assign param_o = code_next;
        end
    endgenerate

endmodule

// File: rtl/bxpe_param_extract_chk.sv
module bxpe_param_extract_chk #(
    parameter int DATA_W  = bxpe_pkg::DATA_W,
    parameter int NUM_BLK = bxpe_pkg::NUM_BLK,
    parameter bit REG_OUT = 1'b1
) (
    input logic               clk,
    input logic               rst,
    input logic [DATA_W-1:0]  data_i,
    input logic               valid_i,
    input logic [NUM_BLK-1:0] param_o
);

    logic [DATA_W-1:0]  d_q;
    logic               v_q;
    logic               armed;
    logic [DATA_W-1:0]  d_s;
    logic               v_s;
    logic               ok;
    logic [NUM_BLK-1:0] ref_raw;
    logic [NUM_BLK-1:0] ref_alt;

    always_ff @(posedge clk) begin
        d_q <= data_i;
        v_q <= valid_i;
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R6: the inputs that the current output must reflect.
    assign d_s = REG_OUT ? d_q : data_i;
    assign v_s = REG_OUT ? v_q : valid_i;
    assign ok  = REG_OUT ? armed : 1'b1;

    always_comb begin
        for (int k = 0; k < NUM_BLK; k++) begin
            ref_raw[k] = 1'b0;
            for (int j = 0; j < DATA_W; j++) begin
                if (j >= bxpe_pkg::blk_lo(k, DATA_W, NUM_BLK) &&
                    j <  bxpe_pkg::blk_lo(k, DATA_W, NUM_BLK) +
                         bxpe_pkg::blk_width(k, DATA_W, NUM_BLK))
                    ref_raw[k] = ref_raw[k] ^ d_s[j];
            end
        end
        ref_alt = '0;
        ref_alt[0] = ^d_s;
        for (int k = 1; k < NUM_BLK - 1; k++) begin
            ref_alt[k] = ref_raw[k+1] ^ d_s[NUM_BLK-2-k];
        end
    end

    AST_EMPTY_WHEN_INVALID: assert property (@(posedge clk) disable iff (rst)
        ok && !v_s |-> param_o == '1); // R2

    AST_VALID_NEVER_EMPTY: assert property (@(posedge clk) disable iff (rst)
        ok && v_s |-> param_o != '1); // R3

    AST_BLOCK_FOLD: assert property (@(posedge clk) disable iff (rst)
        ok && v_s && !(&ref_raw) |-> param_o == ref_raw); // R1

    AST_REMAP_CODE: assert property (@(posedge clk) disable iff (rst)
        ok && v_s && (&ref_raw) |-> param_o == ref_alt); // R4

    generate
        if (REG_OUT) begin : g_rst_chk
            AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
                $fell(rst) |-> param_o == '1); // R7
        end
    endgenerate

endmodule

bind bxpe_param_extract bxpe_param_extract_chk #(
    .DATA_W  (DATA_W),
    .NUM_BLK (NUM_BLK),
    .REG_OUT (REG_OUT)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .data_i  (data_i),
    .valid_i (valid_i),
    .param_o (param_o)
);

// File: tb/bxpe_param_extract_tb.sv
module bxpe_param_extract_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] data_i = '0;
    logic        valid_i = 1'b0;
    logic [3:0]  param_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // {data, valid, expected code}
    localparam logic [18:0] VEC [NVEC] = '{
        {14'h0000, 1'b1, 4'h0},  // R1 all zero
        {14'h1234, 1'b0, 4'hF},  // R2
        {14'h0001, 1'b1, 4'h1},  // R1 block 0
        {14'h0010, 1'b1, 4'h2},  // R1 block 1
        {14'h0100, 1'b1, 4'h4},  // R1 block 2
        {14'h0800, 1'b1, 4'h8},  // R1 block 3
        {14'h0911, 1'b1, 4'h2},  // R4 remap, d0=1 d1=0
        {14'h0912, 1'b1, 4'h4},  // R4 remap, d0=0 d1=1
        {14'h0914, 1'b1, 4'h6},  // R4 remap, d0=0 d1=0
        {14'h0917, 1'b1, 4'h0},  // R4 remap, d0=1 d1=1
        {14'h0913, 1'b1, 4'hE},  // R1 one short of collision
        {14'h3FFF, 1'b1, 4'hC},  // R1 all ones
        {14'h3FFF, 1'b0, 4'hF},  // R2
        {14'h000F, 1'b1, 4'h0},  // R1 even block
        {14'h2000, 1'b1, 4'h8},  // R1 top bit
        {14'h0000, 1'b0, 4'hF}   // R2
    };

    bxpe_param_extract #(.REG_OUT(1'b1)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .data_i  (data_i),
        .valid_i (valid_i),
        .param_o (param_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [3:0] model(input logic [13:0] d, input logic v);
        logic [3:0] r;
        r = {^d[13:11], ^d[10:8], ^d[7:4], ^d[3:0]};
        if (!v) return 4'hF;
        if (r == 4'hF) return {1'b0, r[3] ^ d[0], r[2] ^ d[1], ^d};
        return r;
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R6: drive at a falling edge, sample at the next falling edge.
    task automatic apply(input logic [13:0] d, input logic v);
        data_i  = d;
        valid_i = v;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit seen [16];
        logic [3:0] prev;
        foreach (seen[i]) seen[i] = 1'b0;

        // R7: output is the empty marker during reset, even with valid data.
        data_i  = 14'h0001;
        valid_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 reset", param_o, 4'hF);
        rst = 1'b0;
        @(negedge clk);
        check("R6 first cycle after reset", param_o, 4'h1);

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][18:5], VEC[i][4]);
            check("R1/R2/R4 vector", param_o, VEC[i][3:0]);
        end

        // R6: one cycle of latency. The value before the edge is the old code.
        data_i  = 14'h0800;
        valid_i = 1'b1;
        @(posedge clk);
        prev = param_o;
        @(negedge clk);
        check("R6 old code held until edge", prev, 4'hF);
        check("R6 new code after edge", param_o, 4'h8);

        // R7: reset asserted mid-stream.
        rst = 1'b1;
        @(negedge clk);
        check("R7 mid-stream reset", param_o, 4'hF);
        rst = 1'b0;

        // R3 and R5: full sweep of every data word.
        for (int i = 0; i < 16384; i++) begin
            apply(14'(i), 1'b1);
            check("R3 sweep", param_o, model(14'(i), 1'b1));
            if (param_o == 4'hF) check("R3 never empty", param_o, 4'h0);
            seen[param_o] = 1'b1;
        end
        for (int c = 0; c < 15; c++) begin
            check("R5 code coverage", {3'b0, seen[c]}, 4'h1);
        end

        // R2: invalid words with varied data.
        for (int i = 0; i < 64; i++) begin
            apply(14'(i * 257), 1'b0);
            check("R2 invalid", param_o, 4'hF);
        end

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule